// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs hardware handshaking for one serial channel. On the receive side, it compares the receive FIFO fill level against a pair of thresholds. It drives the active-low RTS pin with hysteresis: RTS is withdrawn when the FIFO is close to full, and it is granted again only after the FIFO has drained to a lower mark. In the 32-entry legacy mode, the threshold pair comes from a fixed four-entry table selected by the 2-bit trigger code. In the 128-entry extended mode, it comes from two programmable registers.

On the transmit side, the block passes the active-low CTS pin through a two-flop synchronizer. When automatic CTS is enabled, a high synchronized CTS removes the transmit-allow signal. The transmitter uses this signal only to decide whether to start a new character, so a character already in progress completes. A rising edge on the synchronized CTS sets a sticky interrupt flag, provided that interrupt is enabled. The host clears the flag by reading modem status, which is indicated by a one-cycle pulse.

Automatic RTS and automatic CTS are enabled independently. With automatic RTS off, the pin reflects a software modem-control bit.

Top module: `uart_autoflow_ctrl`

## Requirements
- R1: After reset the internal RTS state is "granted" (with automatic RTS on, rts_n reads 0), cts_irq is 0 and tx_allow is 1.
- R2: In legacy mode (wide_mode=0), the trigger code 00/01/10/11 selects a withdraw level of 8/16/24/28 and a re-grant level of 0/7/15/23. RTS is withdrawn when rx_count is at or above the withdraw level, and re-granted when rx_count is at or below the re-grant level.
- R3: In extended mode (wide_mode=1), RTS is withdrawn (rts_n=1) when rx_count is at or above flow_hi.
- R4: In extended mode, RTS is re-granted (rts_n=0) when rx_count is at or below flow_lo and below flow_hi. If both conditions hold, withdrawal wins.
- R5: While rx_count lies strictly between the re-grant and withdraw levels, the RTS state keeps its previous value.
- R6: With auto_rts_en=0, rts_n equals the inverse of sw_rts in the same cycle.
- R7: With auto_cts_en=1, tx_allow falls on the second clock edge after cts_n goes high, and rises on the second edge after it returns low. With auto_cts_en=0, tx_allow is 1.
- R8: With cts_irq_en=1, a low-to-high change on cts_n sets cts_irq at the third clock edge. The flag stays set until an msr_read pulse clears it at the next edge. A new edge in the same cycle as the read keeps the flag set.
- R9: With cts_irq_en=0, CTS edges leave cts_irq unchanged.
- R10: The RTS state is registered: after a threshold crossing on rx_count, rts_n changes at the first following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO fill level |
| wide_mode | input | 1 | 1 = extended 128-entry mode, 0 = legacy 32-entry mode |
| trig_code | input | 2 | Legacy trigger code selecting the threshold pair |
| flow_hi | input | CNT_W | Extended-mode withdraw threshold |
| flow_lo | input | CNT_W | Extended-mode re-grant threshold |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| auto_cts_en | input | 1 | Enable automatic CTS gating |
| sw_rts | input | 1 | Software modem-control RTS bit (1 = grant) |
| cts_n | input | 1 | CTS pin, active low, asynchronous |
| cts_irq_en | input | 1 | Enable the CTS-change interrupt |
| msr_read | input | 1 | One-cycle pulse: host read of modem status |
| rts_n | output | 1 | RTS pin, active low |
| tx_allow | output | 1 | Transmitter may start a new character |
| cts_irq | output | 1 | Sticky CTS-change interrupt flag |

## Verification
The RTS path is driven in three ways.
- Directed sweeps walk rx_count across both edges of each legacy pair and a programmed extended pair. These separate the withdraw edge from the re-grant edge and from the hold band.
- A random walk of rx_count, with occasional changes of mode, code and thresholds, includes inverted pairs. This tells correct hysteresis and priority apart from plain level comparison.
- Toggling the enables shows that the software RTS path and the CTS gating are independent of each other.

On the CTS side, single directed pulses fix the exact edge at which tx_allow and cts_irq respond. Random CTS noise, combined with read pulses, exposes the race between setting and clearing the flag.

// File: rtl/flowctl_pkg.sv
// Package: shared types and the legacy threshold table for the flow controller.
// Assumes thresholds fit in 8 bits; users cast to their own count width.
package flowctl_pkg;

    // Withdraw (hi) and re-grant (lo) level pair.
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } level_pair_t;

    // Legacy threshold pair chosen by the 2-bit trigger code.
    function automatic level_pair_t legacy_pair(input logic [1:0] code);
        level_pair_t p;
        case (code)
            2'b00:   begin p.hi = 8'd8;  p.lo = 8'd0;  end
            2'b01:   begin p.hi = 8'd16; p.lo = 8'd7;  end
            2'b10:   begin p.hi = 8'd24; p.lo = 8'd15; end
            default: begin p.hi = 8'd28; p.lo = 8'd23; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/flow_thresh_sel.sv
// Module: flow_thresh_sel
// Selects the active withdraw/re-grant threshold pair: the fixed legacy table
// in 32-entry mode, the programmed registers in 128-entry mode.
// Assumes the legacy levels fit into CNT_W bits.
module flow_thresh_sel
    import flowctl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic [1:0]       trig_code,
    input  logic [CNT_W-1:0] flow_hi,
    input  logic [CNT_W-1:0] flow_lo,
    output logic [CNT_W-1:0] hi_lvl,
    output logic [CNT_W-1:0] lo_lvl
);

    level_pair_t tbl;

    // Pick the threshold pair for the current mode.
    always_comb begin
        tbl = legacy_pair(trig_code);
        if (wide_mode) begin
            hi_lvl = flow_hi;
            lo_lvl = flow_lo;
        end else begin
            hi_lvl = CNT_W'(tbl.hi);
            lo_lvl = CNT_W'(tbl.lo);
        end
    end

    // R2: legacy pairs always leave a gap between the two levels.
    a_r2_legacy_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (hi_lvl > lo_lvl));

endmodule

// File: rtl/rts_hysteresis.sv
// Module: rts_hysteresis
// Holds the registered RTS grant state with hysteresis and muxes the pin
// between the automatic state and the software modem-control bit.
// Assumes rx_count is synchronous to clk.
module rts_hysteresis #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] hi_lvl,
    input  logic [CNT_W-1:0] lo_lvl,
    input  logic             auto_en,
    input  logic             sw_rts,
    output logic             rts_n
);

    logic grant_q;
    logic at_hi;
    logic at_lo;

    // Threshold comparisons.
    always_comb begin
        at_hi = (rx_count >= hi_lvl);
        at_lo = (rx_count <= lo_lvl);
    end

    // Update the grant state only at threshold crossings; withdrawal wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     grant_q <= 1'b1;
        else if (at_hi) grant_q <= 1'b0;
        else if (at_lo) grant_q <= 1'b1;
    end

    // Drive the pin from the automatic state or the software bit.
    always_comb rts_n = auto_en ? !grant_q : !sw_rts;

    // R3: reaching the high level withdraws RTS at the next edge.
    a_r3_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        at_hi |=> !grant_q);
    // R4: draining to the low level re-grants RTS at the next edge.
    a_r4_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        (at_lo && !at_hi) |=> grant_q);
    // R5: inside the band the state holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_lo && !at_hi) |=> $stable(grant_q));
    // R6: manual mode tracks the software bit.
    a_r6_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> (rts_n == !sw_rts));

endmodule

// File: rtl/cts_sync_gate.sv
// Module: cts_sync_gate
// Synchronizes the asynchronous CTS pin, flags its rising (stop-request)
// edge and gates the transmit-allow signal when automatic CTS is on.
// Assumes SYNC_STAGES >= 2.
module cts_sync_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic auto_en,
    output logic stop_rise,
    output logic tx_allow
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cts_hi;

    // Synchronizer chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= cts_n;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_comb cts_hi = sync_q[SYNC_STAGES-1];

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cts_hi;
    end

    // Rising-edge detect and transmit gating.
    always_comb begin
        stop_rise = cts_hi && !prev_q;
        tx_allow  = !(auto_en && cts_hi);
    end

    // R7: a stop request with auto CTS on blocks new characters.
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && cts_hi) |-> !tx_allow);
    // R7: with auto CTS off the transmitter is never held.
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> tx_allow);

endmodule

// File: rtl/cts_irq_latch.sv
// Module: cts_irq_latch
// Sticky interrupt flag set by a CTS stop-request edge and cleared by a
// modem-status read; a new edge beats a concurrent read.
module cts_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_rise,
    input  logic irq_en,
    input  logic msr_read,
    output logic irq
);

    logic set_req;

    always_comb set_req = stop_rise && irq_en;

    // Set on an enabled edge, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (set_req)  irq <= 1'b1;
        else if (msr_read) irq <= 1'b0;
    end

    // R8: an enabled edge sets the flag at the next edge.
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> irq);
    // R8: a read without a new edge clears the flag.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_read && !set_req) |=> !irq);
    // R9: with no enabled edge the flag never rises.
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !set_req) |=> !irq);

endmodule

// File: rtl/uart_autoflow_ctrl.sv
// Module: uart_autoflow_ctrl
// Top of the automatic RTS/CTS flow controller for one serial channel.
// Assumes rx_count and control inputs are synchronous; cts_n may be async.
module uart_autoflow_ctrl #(
    parameter int FIFO_DEPTH  = 128,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             wide_mode,
    input  logic [1:0]       trig_code,
    input  logic [CNT_W-1:0] flow_hi,
    input  logic [CNT_W-1:0] flow_lo,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic             cts_n,
    input  logic             cts_irq_en,
    input  logic             msr_read,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             cts_irq
);

    logic [CNT_W-1:0] hi_lvl;
    logic [CNT_W-1:0] lo_lvl;
    logic             stop_rise;

    flow_thresh_sel #(.CNT_W(CNT_W)) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .trig_code (trig_code),
        .flow_hi   (flow_hi),
        .flow_lo   (flow_lo),
        .hi_lvl    (hi_lvl),
        .lo_lvl    (lo_lvl)
    );

    rts_hysteresis #(.CNT_W(CNT_W)) u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .hi_lvl   (hi_lvl),
        .lo_lvl   (lo_lvl),
        .auto_en  (auto_rts_en),
        .sw_rts   (sw_rts),
        .rts_n    (rts_n)
    );

    cts_sync_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_n     (cts_n),
        .auto_en   (auto_cts_en),
        .stop_rise (stop_rise),
        .tx_allow  (tx_allow)
    );

    cts_irq_latch u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_rise (stop_rise),
        .irq_en    (cts_irq_en),
        .msr_read  (msr_read),
        .irq       (cts_irq)
    );

    // R1: the cycle after reset, the flag is clear and transmission allowed.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!cts_irq && tx_allow));

endmodule

// File: tb/uart_autoflow_ctrl_test.sv
// Bench for uart_autoflow_ctrl: directed corners plus seeded random stimulus,
// compared every cycle against a requirement-level reference model.
module uart_autoflow_ctrl_test;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic          wide_mode = 1'b0;
    logic [1:0]    trig_code = 2'b00;
    logic [CW-1:0] flow_hi = 8'd100;
    logic [CW-1:0] flow_lo = 8'd40;
    logic          auto_rts_en = 1'b1;
    logic          auto_cts_en = 1'b0;
    logic          sw_rts = 1'b0;
    logic          cts_n = 1'b0;
    logic          cts_irq_en = 1'b0;
    logic          msr_read = 1'b0;
    logic          rts_n;
    logic          tx_allow;
    logic          cts_irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Reference model state.
    bit m_on = 1, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_irq = 0;

    always #10 clk = ~clk;

    uart_autoflow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .wide_mode(wide_mode),
        .trig_code(trig_code), .flow_hi(flow_hi), .flow_lo(flow_lo),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts(sw_rts),
        .cts_n(cts_n), .cts_irq_en(cts_irq_en), .msr_read(msr_read),
        .rts_n(rts_n), .tx_allow(tx_allow), .cts_irq(cts_irq)
    );

    function automatic int exp_hi();
        if (wide_mode) return int'(flow_hi);
        case (trig_code)
            2'b00: return 8; 2'b01: return 16; 2'b10: return 24; default: return 28;
        endcase
    endfunction

    function automatic int exp_lo();
        if (wide_mode) return int'(flow_lo);
        case (trig_code)
            2'b00: return 0; 2'b01: return 7; 2'b10: return 15; default: return 23;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step(input string tag);
        bit rise;
        @(posedge clk);
        if (int'(rx_count) >= exp_hi())      m_on = 0;
        else if (int'(rx_count) <= exp_lo()) m_on = 1;
        rise = m_s2 && !m_s3;
        if (rise && cts_irq_en) m_irq = 1;
        else if (msr_read)      m_irq = 0;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_n;
        @(negedge clk);
        check({tag, " rts_n"},    rts_n,    auto_rts_en ? !m_on : !sw_rts);
        check({tag, " tx_allow"}, tx_allow, !(auto_cts_en && m_s2));
        check({tag, " cts_irq"},  cts_irq,  m_irq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check("R1 rts_n", rts_n, 1'b0);
        check("R1 tx_allow", tx_allow, 1'b1);
        check("R1 cts_irq", cts_irq, 1'b0);

        // R2 / R10: legacy code 01, withdraw at 16, re-grant at 7.
        trig_code = 2'b01;
        rx_count = 8'd15; step("R2");  check("R2 below hi", rts_n, 1'b0);
        rx_count = 8'd16; step("R10"); check("R10 withdraw next edge", rts_n, 1'b1);
        rx_count = 8'd8;  step("R5");  check("R5 hold high", rts_n, 1'b1);
        rx_count = 8'd7;  step("R2");  check("R2 regrant at 7", rts_n, 1'b0);
        rx_count = 8'd15; step("R5");  check("R5 hold low", rts_n, 1'b0);
        // R2: code 11 levels 28/23.
        trig_code = 2'b11;
        rx_count = 8'd27; step("R2");  check("R2 code11 27", rts_n, 1'b0);
        rx_count = 8'd28; step("R2");  check("R2 code11 28", rts_n, 1'b1);
        rx_count = 8'd24; step("R5");  check("R5 code11 24", rts_n, 1'b1);
        rx_count = 8'd23; step("R2");  check("R2 code11 23", rts_n, 1'b0);

        // R3 / R4: extended levels 100/40.
        wide_mode = 1'b1;
        rx_count = 8'd99;  step("R5"); check("R5 ext 99", rts_n, 1'b0);
        rx_count = 8'd100; step("R3"); check("R3 ext 100", rts_n, 1'b1);
        rx_count = 8'd60;  step("R5"); check("R5 ext 60", rts_n, 1'b1);
        rx_count = 8'd40;  step("R4"); check("R4 ext 40", rts_n, 1'b0);
        // R4: inverted pair, withdrawal wins.
        flow_hi = 8'd30; flow_lo = 8'd50; rx_count = 8'd35;
        step("R4"); check("R4 priority", rts_n, 1'b1);

        // R6: manual RTS.
        auto_rts_en = 1'b0; sw_rts = 1'b1;
        step("R6"); check("R6 sw grant", rts_n, 1'b0);
        sw_rts = 1'b0;
        step("R6"); check("R6 sw withdraw", rts_n, 1'b1);

        // R7 / R8: CTS stop request.
        auto_cts_en = 1'b1; cts_irq_en = 1'b1; cts_n = 1'b1;
        step("R7"); check("R7 first edge", tx_allow, 1'b1);
        step("R7"); check("R7 second edge", tx_allow, 1'b0);
        check("R8 not yet", cts_irq, 1'b0);
        step("R8"); check("R8 set third edge", cts_irq, 1'b1);
        step("R8"); check("R8 sticky", cts_irq, 1'b1);
        msr_read = 1'b1;
        step("R8"); check("R8 cleared", cts_irq, 1'b0);
        msr_read = 1'b0;
        cts_n = 1'b0;
        step("R7"); step("R7"); check("R7 released", tx_allow, 1'b1);
        // R9: disabled interrupt ignores the edge.
        cts_irq_en = 1'b0; cts_n = 1'b1;
        repeat (5) step("R9");
        check("R9 ignored", cts_irq, 1'b0);
        cts_n = 1'b0; repeat (3) step("R9");
        // R7: auto CTS off never holds the transmitter.
        auto_cts_en = 1'b0; cts_n = 1'b1;
        repeat (3) step("R7");
        check("R7 bypass", tx_allow, 1'b1);

        // Random phase: walking FIFO level, noisy CTS, occasional reconfig.
        auto_rts_en = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                wide_mode = $urandom_range(0, 1) == 1;
                trig_code = 2'($urandom_range(0, 3));
                flow_hi   = 8'($urandom_range(1, 128));
                flow_lo   = 8'($urandom_range(0, 128));
            end
            if (wide_mode) begin
                if ($urandom_range(0, 1) == 1 && rx_count < 8'd128) rx_count = rx_count + 8'd1;
                else if (rx_count > 0) rx_count = rx_count - 8'd1;
            end else begin
                if ($urandom_range(0, 1) == 1 && rx_count < 8'd32) rx_count = rx_count + 8'd1;
                else if (rx_count > 0) rx_count = rx_count - 8'd1;
                if (rx_count > 8'd32) rx_count = 8'd32;
            end
            if (r >= 95) auto_rts_en = !auto_rts_en;
            if (r % 7 == 0) cts_n = !cts_n;
            auto_cts_en = ($urandom_range(0, 3) != 0);
            cts_irq_en  = ($urandom_range(0, 4) != 0);
            sw_rts      = $urandom_range(0, 1) == 1;
            msr_read    = ($urandom_range(0, 5) == 0);
            step("R3/R4/R5/R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule